// File: doc/BRIEF.md
# Reserved Doubleword Load / Conditional Store Unit

This unit carries out the two halves of a lock-free update for one hart: a reserving load and a conditional store, both on 64-bit doublewords. A reserving load reads memory through a synchronous port, hands the value back for the destination register and remembers the doubleword it came from. A conditional store writes its data only if that doubleword is still reserved. The store then returns the integer 0 on success or 1 on failure, and a store that fails never reaches memory.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The unit takes one request at a time, so `req_ready` stays low from acceptance until the result has been taken. A result is held, unchanged, until the edge where `rsp_valid` and `rsp_ready` are both high. Ordinary stores issued elsewhere by the same hart are reported on a plain snoop input, and these clear a matching reservation.

Only one reservation exists. It is a valid bit plus a doubleword address. A newer reserving load replaces it. Every conditional store removes it, and so does a snooped store to the same doubleword. An address with nonzero low three bits is rejected with an alignment fault and no memory access.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset, `rsp_valid` and `mem_en` are 0 and `req_ready` is 1, and no reservation is held. A conditional store issued at this point therefore fails.
- R2: A reserving load (`req_op`=0) to an aligned address reads the doubleword at that address. Its result appears on `rsp_valid` two cycles after acceptance, carrying the value sign-extended to XLEN, with `rsp_rd_we`=1 and `rsp_fault`=0. The load records a reservation for that doubleword.
- R3: A conditional store (`req_op`=1) to a reserved doubleword writes `req_wdata` to memory and returns `rsp_data`=0. Its result appears one cycle after acceptance.
- R4: A conditional store to a doubleword that is not reserved returns `rsp_data`=1 and does not assert `mem_we`.
- R5: Every conditional store removes the reservation, whether it succeeds or fails, so a second conditional store to the same doubleword fails.
- R6: A newer reserving load moves the reservation to its own address, and the earlier address is no longer reserved.
- R7: A snoop store (`snoop_valid`=1) clears the reservation when `snoop_addr` bits [ADDR_W-1:3] match the reserved doubleword. A snoop to another doubleword leaves the reservation in place. A matching snoop in the same cycle in which a conditional store is checked makes that store fail.
- R8: A request whose address bits [2:0] are nonzero makes no memory access. It returns `rsp_fault`=1, `rsp_data`=0 and `rsp_rd_we`=0, and it leaves the reservation unchanged.
- R9: With `req_rd_zero`=1, the result still carries its data but `rsp_rd_we` is 0. Memory and the reservation are affected exactly as they would be with `req_rd_zero`=0.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, the result fields stay stable. `req_ready` is 0 while a result is pending.
- R11: `mem_we` is asserted only together with `mem_en`, and any memory access uses a doubleword-aligned address. Read data is expected on `mem_rdata` one cycle after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 1 | 0 = reserving load, 1 = conditional store |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | XLEN | Store data (low 64 bits written) |
| req_rd_zero | input | 1 | Destination is register zero |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | XLEN | Loaded value, or 0/1 store status |
| rsp_rd_we | output | 1 | Destination register should be written |
| rsp_fault | output | 1 | Misaligned address fault |
| snoop_valid | input | 1 | An ordinary store is happening this cycle |
| snoop_addr | input | ADDR_W | Byte address of that store |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (with mem_en) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, one cycle after a read |

## Verification
On every cycle the assertions check the memory-port rules, the holding of results under back-pressure, the blocking of new requests while a result is pending, and the absence of register writes on a faulted request. They also check that each memory write is followed at once by a success code. Only the bench's scenarios can show the reservation's history: that it is replaced by a newer load, cleared by every store attempt and by matching snoops but not by snoops to other doublewords, and left alone by a misaligned request. The bench also shows that memory contents change only on a successful store.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [0:0] {
    OP_LOAD_RSV  = 1'b0,
    OP_STORE_CND = 1'b1
  } lrsc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_CAPT = 2'd2
  } lrsc_state_e;

  localparam int unsigned DWORD_W   = 64;
  localparam int unsigned DW_OFFS_W = 3;
endpackage

// File: rtl/lrsc_resv_tracker.sv
module lrsc_resv_tracker #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              hit
);
  localparam int unsigned LINE_W = ADDR_W - lrsc_pkg::DW_OFFS_W;

  logic              rsv_valid_q;
  logic [LINE_W-1:0] rsv_line_q;
  logic              snoop_hit;

  assign snoop_hit = snoop_valid && rsv_valid_q &&
                     (snoop_addr[ADDR_W-1:lrsc_pkg::DW_OFFS_W] == rsv_line_q);

  // A store check sees the held reservation minus any same-cycle snoop.
  assign hit = rsv_valid_q && !snoop_hit &&
               (chk_addr[ADDR_W-1:lrsc_pkg::DW_OFFS_W] == rsv_line_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv_valid_q <= 1'b0;
      rsv_line_q  <= '0;
    end else if (set_en) begin
      rsv_valid_q <= 1'b1;
      rsv_line_q  <= set_addr[ADDR_W-1:lrsc_pkg::DW_OFFS_W];
    end else if (clr_en || snoop_hit) begin
      rsv_valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lrsc_rsp_slot.sv
module lrsc_rsp_slot #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] load_data,
  input  logic            load_we,
  input  logic            load_fault,
  output logic            busy,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [XLEN-1:0] rsp_data,
  output logic            rsp_rd_we,
  output logic            rsp_fault
);
  logic            valid_q;
  logic [XLEN-1:0] data_q;
  logic            we_q;
  logic            fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      we_q    <= 1'b0;
      fault_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= load_data;
      we_q    <= load_we;
      fault_q <= load_fault;
    end else if (valid_q && rsp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign busy      = valid_q;
  assign rsp_valid = valid_q;
  assign rsp_data  = data_q;
  assign rsp_rd_we = we_q;
  assign rsp_fault = fault_q;
endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic              req_rd_zero,
  input  logic              slot_busy,
  output logic              slot_load,
  output logic [XLEN-1:0]   slot_data,
  output logic              slot_we,
  output logic              slot_fault,
  input  logic              rsv_hit,
  output logic              rsv_set,
  output logic              rsv_clr,
  output logic [ADDR_W-1:0] op_addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata
);
  import lrsc_pkg::*;

  localparam int unsigned EXT_W = XLEN - DWORD_W;

  lrsc_state_e       state_q;
  lrsc_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [63:0]       wdata_q;
  logic              rdz_q;
  logic              mis_q;
  logic              accept;
  logic [XLEN-1:0]   load_ext;

  generate
    if (EXT_W > 0) begin : g_sext
      assign load_ext = {{EXT_W{mem_rdata[63]}}, mem_rdata};
    end else begin : g_plain
      assign load_ext = mem_rdata[XLEN-1:0];
    end
  endgenerate

  assign req_ready = (state_q == ST_IDLE) && !slot_busy;
  assign accept    = req_valid && req_ready;
  assign op_addr   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LOAD_RSV;
      addr_q  <= '0;
      wdata_q <= '0;
      rdz_q   <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_EXEC;
          op_q    <= lrsc_op_e'(req_op);
          addr_q  <= req_addr;
          wdata_q <= req_wdata[63:0];
          rdz_q   <= req_rd_zero;
          mis_q   <= (req_addr[DW_OFFS_W-1:0] != '0);
        end
        ST_EXEC: begin
          if (!mis_q && op_q == OP_LOAD_RSV) state_q <= ST_CAPT;
          else                               state_q <= ST_IDLE;
        end
        ST_CAPT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = addr_q;
    mem_wdata  = wdata_q;
    slot_load  = 1'b0;
    slot_data  = '0;
    slot_we    = 1'b0;
    slot_fault = 1'b0;
    rsv_set    = 1'b0;
    rsv_clr    = 1'b0;
    case (state_q)
      ST_EXEC: begin
        if (mis_q) begin
          slot_load  = 1'b1;
          slot_fault = 1'b1;
        end else if (op_q == OP_STORE_CND) begin
          mem_en    = rsv_hit;
          mem_we    = rsv_hit;
          slot_load = 1'b1;
          slot_data = rsv_hit ? '0 : XLEN'(1);
          slot_we   = !rdz_q;
          rsv_clr   = 1'b1;
        end else begin
          mem_en = 1'b1;
        end
      end
      ST_CAPT: begin
        slot_load = 1'b1;
        slot_data = load_ext;
        slot_we   = !rdz_q;
        rsv_set   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic              req_rd_zero,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [XLEN-1:0]   rsp_data,
  output logic              rsp_rd_we,
  output logic              rsp_fault,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata
);
  logic              slot_busy;
  logic              slot_load;
  logic [XLEN-1:0]   slot_data;
  logic              slot_we;
  logic              slot_fault;
  logic              rsv_hit;
  logic              rsv_set;
  logic              rsv_clr;
  logic [ADDR_W-1:0] op_addr;

  lrsc_ctrl #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rd_zero(req_rd_zero),
    .slot_busy(slot_busy), .slot_load(slot_load), .slot_data(slot_data),
    .slot_we(slot_we), .slot_fault(slot_fault),
    .rsv_hit(rsv_hit), .rsv_set(rsv_set), .rsv_clr(rsv_clr), .op_addr(op_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  lrsc_resv_tracker #(.ADDR_W(ADDR_W)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .set_en(rsv_set), .clr_en(rsv_clr), .set_addr(op_addr), .chk_addr(op_addr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .hit(rsv_hit)
  );

  lrsc_rsp_slot #(.XLEN(XLEN)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .load(slot_load), .load_data(slot_data), .load_we(slot_we),
    .load_fault(slot_fault), .busy(slot_busy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_rd_we(rsp_rd_we), .rsp_fault(rsp_fault)
  );
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [XLEN-1:0]   rsp_data,
  input logic              rsp_rd_we,
  input logic              rsp_fault,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  // R11
  mem_we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  // R11
  mem_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[2:0] == 3'd0));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
                                   $stable(rsp_rd_we) && $stable(rsp_fault)));

  // R10
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R8
  fault_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (!rsp_rd_we && rsp_data == '0));

  // R3
  write_then_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (rsp_valid && rsp_data == '0 && !rsp_fault));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_rd_we(rsp_rd_we), .rsp_fault(rsp_fault),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/test_lrsc_monitor.sv
module test_lrsc_monitor;
  localparam int XLEN   = 64;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_op = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [XLEN-1:0]   req_wdata = '0;
  logic              req_rd_zero = 1'b0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [XLEN-1:0]   rsp_data;
  logic              rsp_rd_we;
  logic              rsp_fault;
  logic              snoop_valid = 1'b0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic              mem_en;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0]       mem_wdata;
  logic [63:0]       mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int acc_cnt = 0;
  bit done = 0;

  logic [63:0]       mem [16];
  logic [XLEN+1:0]   exp_q [$];
  string             tag_q [$];

  always #5 clk = ~clk;

  lrsc_monitor #(.XLEN(XLEN), .ADDR_W(ADDR_W)) i_lrsc_monitor (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rd_zero(req_rd_zero),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_rd_we(rsp_rd_we), .rsp_fault(rsp_fault),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [63:0] init_val(int i);
    return {32'hC0DE_0000 | 32'(i), 32'h0000_1000 | 32'(i)};
  endfunction

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[6:3]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[6:3]];
    end
  end

  task automatic check(input bit ok, input string msg, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", msg, act, exp);
    end
  endtask

  // monitor: drives ready pattern, pops scoreboard on handshake
  int cyc = 0;
  bit prev_stall = 0;
  logic [XLEN+1:0] prev_rsp;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_stall)
        check(rsp_valid && {rsp_data, rsp_rd_we, rsp_fault} == prev_rsp,
              "R10 result held under back-pressure", rsp_data, prev_rsp[XLEN+1:2]);
      if (rsp_valid)
        check(!req_ready, "R10 req_ready low while result pending",
              XLEN'(req_ready), '0);
      rsp_ready = (cyc % 3) != 1;
      prev_stall = rsp_valid && !rsp_ready;
      prev_rsp = {rsp_data, rsp_rd_we, rsp_fault};
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "unexpected response", rsp_data, '0);
        end else begin
          logic [XLEN+1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == e[XLEN+1:2], {t, " data"}, rsp_data, e[XLEN+1:2]);
          check(rsp_rd_we == e[1], {t, " rd_we"}, XLEN'(rsp_rd_we), XLEN'(e[1]));
          check(rsp_fault == e[0], {t, " fault"}, XLEN'(rsp_fault), XLEN'(e[0]));
        end
      end
    end
  end

  task automatic do_req(input bit op, input logic [ADDR_W-1:0] addr,
                        input logic [XLEN-1:0] wdata, input bit rdz, input bit snp,
                        input logic [XLEN-1:0] e_data, input bit e_we, input bit e_fault,
                        input string tag);
    exp_q.push_back({e_data, e_we, e_fault});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_wdata = wdata; req_rd_zero = rdz;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
    if (snp) begin
      snoop_valid = 1; snoop_addr = addr;
      @(posedge clk);
      #1 snoop_valid = 0;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  task automatic snoop(input logic [ADDR_W-1:0] addr);
    drain();
    snoop_valid = 1; snoop_addr = addr;
    @(negedge clk);
    snoop_valid = 0;
  endtask

  task automatic check_mem(input int idx, input logic [63:0] exp, input string msg);
    drain();
    check(mem[idx] == exp, msg, mem[idx], exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int a0;
    for (int i = 0; i < 16; i++) mem[i] = init_val(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!rsp_valid, "R1 rsp_valid after reset", XLEN'(rsp_valid), '0);
    check(req_ready, "R1 req_ready after reset", XLEN'(req_ready), 1);
    check(!mem_en, "R1 mem_en after reset", XLEN'(mem_en), '0);
    // R1 R4: no reservation after reset, store fails
    do_req(1, 32'h10, 64'h1111, 0, 0, 1, 1, 0, "R1 R4 store without reservation");
    check_mem(2, init_val(2), "R4 failed store left memory");
    // R2 load
    do_req(0, 32'h10, 0, 0, 0, init_val(2), 1, 0, "R2 reserving load");
    // R3 store success
    do_req(1, 32'h10, 64'hD1D1_0000_0000_0001, 0, 0, 0, 1, 0, "R3 store succeeds");
    check_mem(2, 64'hD1D1_0000_0000_0001, "R3 memory written");
    // R5 second store fails
    do_req(1, 32'h10, 64'hBAD0, 0, 0, 1, 1, 0, "R5 second store fails");
    check_mem(2, 64'hD1D1_0000_0000_0001, "R5 memory unchanged");
    // R6 replacement
    do_req(0, 32'h18, 0, 0, 0, init_val(3), 1, 0, "R6 load A");
    do_req(0, 32'h20, 0, 0, 0, init_val(4), 1, 0, "R6 load B");
    do_req(1, 32'h18, 64'hBAD1, 0, 0, 1, 1, 0, "R6 store to old address fails");
    check_mem(3, init_val(3), "R6 memory unchanged");
    // R7 snoop to other dword keeps reservation
    do_req(0, 32'h28, 0, 0, 0, init_val(5), 1, 0, "R7 load");
    snoop(32'h30);
    do_req(1, 32'h28, 64'hD4, 0, 0, 0, 1, 0, "R7 other-dword snoop keeps reservation");
    check_mem(5, 64'hD4, "R7 memory written");
    // R7 snoop to same dword, different byte, clears
    do_req(0, 32'h28, 0, 0, 0, 64'hD4, 1, 0, "R7 reload");
    snoop(32'h2C);
    do_req(1, 32'h28, 64'hBAD2, 0, 0, 1, 1, 0, "R7 matching snoop clears");
    check_mem(5, 64'hD4, "R7 memory unchanged after clear");
    // R7 snoop in the same cycle as the check
    do_req(0, 32'h40, 0, 0, 0, init_val(8), 1, 0, "R7 load for same-cycle snoop");
    do_req(1, 32'h40, 64'hBAD3, 0, 1, 1, 1, 0, "R7 same-cycle snoop fails store");
    check_mem(8, init_val(8), "R7 memory unchanged same-cycle");
    // R8 misaligned
    do_req(0, 32'h48, 0, 0, 0, init_val(9), 1, 0, "R8 load");
    drain();
    a0 = acc_cnt;
    do_req(1, 32'h4C, 64'hBAD4, 0, 0, 0, 0, 1, "R8 misaligned store faults");
    do_req(0, 32'h43, 0, 0, 0, 0, 0, 1, "R8 misaligned load faults");
    drain();
    check(acc_cnt == a0, "R8 no memory access", XLEN'(acc_cnt), XLEN'(a0));
    do_req(1, 32'h48, 64'hD5, 0, 0, 0, 1, 0, "R8 reservation kept after fault");
    check_mem(9, 64'hD5, "R8 memory written");
    // R9 rd zero
    do_req(0, 32'h50, 0, 1, 0, init_val(10), 0, 0, "R9 load with rd zero");
    do_req(1, 32'h50, 64'hD6, 1, 0, 0, 0, 0, "R9 store with rd zero succeeds");
    check_mem(10, 64'hD6, "R9 memory written");
    do_req(1, 32'h50, 64'hBAD5, 1, 0, 1, 0, 0, "R9 rd zero store then fails");
    check_mem(10, 64'hD6, "R9 memory unchanged");
    drain();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule